// File: doc/BRIEF.md
# Paged Work-RAM and Expansion Decoder

This block decodes the CPU window from 0x5000 to 0x7FFF on a cartridge. Accesses in 0x5000..0x5FFF go to a small expansion scratch RAM. Accesses in 0x6000..0x7FFF go either to a default work-RAM bank or to one of four alternate work-RAM pages. A control byte, written through the register port at 0xA001 and its mirrors, decides which of these is used.

When alternate page 0 is selected, a write lands both in that page and in the default bank, so the default bank always holds a copy of what was written there. The decoder also watches one expansion address. When the value 2 is written to it, the decoder sends a one-cycle request to the program-bank unit, which then forces all four program windows to bank 0.

Reads are registered. Data and a valid flag appear in the cycle after the read strobe. The page offset is the low `PAGE_AW` address bits, which is 13 bits in a full 8 KB build. The expansion offset is the low `XRAM_AW` bits, which is 12 bits in a full 4 KB build. The default parameters build 512-byte arrays, so in that build higher address bits alias.

Top module: `wramPageDecoder`

## Requirements
- R1: A write in 0x5000..0x5FFF stores the byte in expansion RAM at offset cpuAddr[XRAM_AW-1:0], and a later read of that address returns it. Such a write never touches any work-RAM page.
- R2: A write whose address satisfies (addr & 0xE001) == 0xA001 loads the control byte, and only such writes do. An access in the following cycle already uses the new value. Only the bits set in 0xE3 take part in page selection.
- R3: For accesses in 0x6000..0x7FFF, a masked control value of 0xE0, 0xE1, 0xE2 or 0xE3 selects alternate page 0, 1, 2 or 3, taken from the masked value's low two bits. Any other masked value selects the default bank.
- R4: A write while alternate page 0 is selected updates alternate page 0 and the default bank at the same offset.
- R5: A write while alternate page 1, 2 or 3 is selected updates only that page, and the default bank keeps its contents.
- R6: A write of 0x02 to 0x5FF3 raises forceLayoutPulse for exactly the next cycle. A different value, or a different address, raises no pulse. The byte is still stored in expansion RAM as in R1.
- R7: The work-RAM offset is cpuAddr[PAGE_AW-1:0]. Addresses that differ only above that field reach the same byte.
- R8: After reset the control byte is 0, so the default bank is selected. Alternate pages 0, 2 and 3 read as zero. rdValid and forceLayoutPulse are low.
- R9: A read in 0x5000..0x7FFF returns rdData with rdValid high in the cycle after cpuRdEn. A read outside that range leaves rdValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuWrEn | input | 1 | Write strobe, one cycle per write |
| cpuRdEn | input | 1 | Read strobe, one cycle per read |
| rdData | output | 8 | Registered read data |
| rdValid | output | 1 | rdData is valid for the read issued the cycle before |
| forceLayoutPulse | output | 1 | One-cycle request to force all program windows to bank 0 |

## Verification
A wrong control byte or page index shows as wrong data on the very next read of 0x6000..0x7FFF. The bench therefore reads back after every page switch and compares the result against the value the selected page should hold.

A lost mirror write in page 0, or a leak from pages 1..3 into the default bank, only appears once the control byte returns to the default selection. Each such case is therefore followed by a default-bank read of the same offset.

A fault in the force-layout trigger shows on forceLayoutPulse one cycle after the write. The bench checks both that cycle and the one after it.

// File: rtl/wramPkg.sv
package wramPkg;
  localparam int ALT_PAGES = 4;
  localparam logic [2:0] SRC_DEF = 3'd4;

  typedef struct packed {
    logic                 xramWr;
    logic                 xramRd;
    logic [ALT_PAGES-1:0] altWr;
    logic                 defWr;
    logic                 pageRd;
    logic [2:0]           rdSrc;
    logic                 forceHit;
  } decStrobes_t;
endpackage

// File: rtl/wramDecodeCtrl.sv
module wramDecodeCtrl
  import wramPkg::*;
#(
  parameter logic [7:0]  CTRL_MASK  = 8'hE3,
  parameter logic [7:0]  ALT_MATCH  = 8'hE0,
  parameter logic [15:0] CTRL_ADDR  = 16'hA001,
  parameter logic [15:0] CTRL_DECODE = 16'hE001,
  parameter logic [15:0] FORCE_ADDR = 16'h5FF3,
  parameter logic [7:0]  FORCE_VAL  = 8'h02,
  parameter int          MIRROR_PAGE = 0
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWrEn,
  input  logic        cpuRdEn,
  output decStrobes_t strobes
);
  logic [7:0] ctrlByte;
  logic [7:0] maskedCtrl;
  logic       ctrlWe, inXram, inPage, altHit;
  logic [1:0] altIdx;
  logic [ALT_PAGES-1:0] altWrVec;

  assign ctrlWe     = cpuWrEn && ((cpuAddr & CTRL_DECODE) == CTRL_ADDR);
  assign maskedCtrl = ctrlByte & CTRL_MASK;
  assign altHit     = (maskedCtrl & ~8'h03) == ALT_MATCH;
  assign altIdx     = maskedCtrl[1:0];
  assign inXram     = cpuAddr[15:12] == 4'h5;
  assign inPage     = cpuAddr[15:13] == 3'b011;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlByte <= '0;
    else if (ctrlWe) ctrlByte <= cpuWrData;
  end

  for (genvar i = 0; i < ALT_PAGES; i++) begin : g_altWr
    assign altWrVec[i] = cpuWrEn && inPage && altHit && (altIdx == 2'(i));
  end

  always_comb begin
    strobes          = '0;
    strobes.xramWr   = cpuWrEn && inXram;
    strobes.xramRd   = cpuRdEn && inXram;
    strobes.pageRd   = cpuRdEn && inPage;
    strobes.rdSrc    = altHit ? {1'b0, altIdx} : SRC_DEF;
    strobes.altWr    = altWrVec;
    strobes.defWr    = cpuWrEn && inPage && (!altHit || altIdx == 2'(MIRROR_PAGE));
    strobes.forceHit = cpuWrEn && (cpuAddr == FORCE_ADDR) && (cpuWrData == FORCE_VAL);
  end

  AST_MIRROR_PAGE0: assert property (@(posedge clk) disable iff (!rstN)
    strobes.altWr[MIRROR_PAGE] |-> strobes.defWr); // R4
  AST_ALT_ISOLATE: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.altWr[ALT_PAGES-1:1]) |-> !strobes.defWr); // R5
  AST_XRAM_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.xramWr |-> (strobes.altWr == '0 && !strobes.defWr)); // R1
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWrEn |=> $stable(ctrlByte)); // R2
endmodule

// File: rtl/wramDataPath.sv
module wramDataPath
  import wramPkg::*;
#(
  parameter int                 XRAM_AW     = 9,
  parameter int                 PAGE_AW     = 9,
  parameter logic [ALT_PAGES-1:0] CLEAR_PAGES = 4'b1101
)(
  input  logic               clk,
  input  logic               rstN,
  input  decStrobes_t        strobes,
  input  logic [XRAM_AW-1:0] xramOff,
  input  logic [PAGE_AW-1:0] pageOff,
  input  logic [7:0]         wrData,
  output logic [7:0]         rdData,
  output logic               rdValid,
  output logic               forcePulse
);
  localparam int XRAM_DEPTH = 1 << XRAM_AW;
  localparam int PAGE_DEPTH = 1 << PAGE_AW;

  logic [7:0] xramMem [XRAM_DEPTH];
  logic [7:0] defMem  [PAGE_DEPTH];
  logic [ALT_PAGES-1:0][7:0] altRdWord;
  logic [7:0] xramRdWord, defRdWord;

  always_ff @(posedge clk) begin
    if (strobes.xramWr) xramMem[xramOff] <= wrData;
    if (strobes.defWr)  defMem[pageOff]  <= wrData;
  end
  assign xramRdWord = xramMem[xramOff];
  assign defRdWord  = defMem[pageOff];

  for (genvar p = 0; p < ALT_PAGES; p++) begin : g_page
    logic [7:0] pageMem [PAGE_DEPTH];
    if (CLEAR_PAGES[p]) begin : g_clr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int k = 0; k < PAGE_DEPTH; k++) pageMem[k] <= '0;
        end else if (strobes.altWr[p]) begin
          pageMem[pageOff] <= wrData;
        end
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (strobes.altWr[p]) pageMem[pageOff] <= wrData;
      end
    end
    assign altRdWord[p] = pageMem[pageOff];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData     <= '0;
      rdValid    <= 1'b0;
      forcePulse <= 1'b0;
    end else begin
      rdValid    <= strobes.xramRd || strobes.pageRd;
      forcePulse <= strobes.forceHit;
      if (strobes.xramRd)
        rdData <= xramRdWord;
      else if (strobes.pageRd)
        rdData <= (strobes.rdSrc == SRC_DEF) ? defRdWord : altRdWord[strobes.rdSrc[1:0]];
    end
  end

  AST_ONE_READ_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.xramRd, strobes.pageRd})); // R9
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceHit |=> forcePulse); // R6
endmodule

// File: rtl/wramPageDecoder.sv
module wramPageDecoder
  import wramPkg::*;
#(
  parameter int XRAM_AW = 9,
  parameter int PAGE_AW = 9
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWrEn,
  input  logic        cpuRdEn,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        forceLayoutPulse
);
  decStrobes_t strobes;

  wramDecodeCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .strobes(strobes)
  );

  wramDataPath #(.XRAM_AW(XRAM_AW), .PAGE_AW(PAGE_AW)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .xramOff(cpuAddr[XRAM_AW-1:0]), .pageOff(cpuAddr[PAGE_AW-1:0]),
    .wrData(cpuWrData), .rdData(rdData), .rdValid(rdValid),
    .forcePulse(forceLayoutPulse)
  );

  AST_FORCE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    forceLayoutPulse |-> $past(cpuWrEn && cpuAddr == 16'h5FF3 && cpuWrData == 8'h02)); // R6
  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(cpuRdEn)); // R9
  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && cpuAddr[15]) |=> !rdValid); // R9
endmodule

// File: tb/wramPageDecoder_test.sv
module wramPageDecoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic cpuWrEn = 1'b0, cpuRdEn = 1'b0;
  logic [7:0] rdData;
  logic rdValid, forceLayoutPulse;

  int vectors = 0, miscompares = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  wramPageDecoder uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .rdData(rdData), .rdValid(rdValid),
    .forceLayoutPulse(forceLayoutPulse)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    cpuAddr = a; cpuRdEn = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    cpuRdEn = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever the design reports a read
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check("R9 unexpected rdValid", 8'h01, 8'h00);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 rdValid in reset", {7'b0, rdValid}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 rdValid after reset", {7'b0, rdValid}, 8'h00);
    check("R8 pulse after reset", {7'b0, forceLayoutPulse}, 8'h00);

    // R8: cleared alternate pages
    wr(16'hA001, 8'hE0); rd(16'h6005, 8'h00, "R8 page0 zero");
    wr(16'hA001, 8'hE2); rd(16'h7FFF, 8'h00, "R8 page2 zero");
    wr(16'hA001, 8'hE3); rd(16'h6005, 8'h00, "R8 page3 zero");

    // R3: default bank
    wr(16'hA001, 8'h00);
    wr(16'h6010, 8'h11); wr(16'h6030, 8'h01);
    rd(16'h6010, 8'h11, "R3 default bank");

    // R1: expansion RAM
    wr(16'h5123, 8'hA5); wr(16'h5001, 8'h3C);
    rd(16'h5123, 8'hA5, "R1 xram 5123");
    rd(16'h5001, 8'h3C, "R1 xram 5001");
    rd(16'h6010, 8'h11, "R1 xram write left default bank");

    // R4: mirror into default bank
    wr(16'hA001, 8'hE0); wr(16'h6020, 8'h55);
    rd(16'h6020, 8'h55, "R4 page0 data");
    wr(16'hA001, 8'h00);
    rd(16'h6020, 8'h55, "R4 mirror in default");

    // R5: pages 1..3 isolated
    wr(16'hA001, 8'hE1); wr(16'h6010, 8'h77);
    rd(16'h6010, 8'h77, "R5 page1 data");
    wr(16'hA001, 8'h00);
    rd(16'h6010, 8'h11, "R5 default untouched by page1");
    wr(16'hA001, 8'hE2); wr(16'h6030, 8'h99);
    wr(16'hA001, 8'hE3);
    rd(16'h6030, 8'h00, "R5 page3 untouched by page2");
    wr(16'hA001, 8'hE2);
    rd(16'h6030, 8'h99, "R3 page2 data");
    wr(16'hA001, 8'h00);
    rd(16'h6030, 8'h01, "R5 default untouched by page2");

    // R2: masking, mirrored register address, even address ignored
    wr(16'hA001, 8'hFD);
    rd(16'h6010, 8'h77, "R2 masked FD selects page1");
    wr(16'hA001, 8'hC1);
    rd(16'h6010, 8'h11, "R2 masked C1 selects default");
    wr(16'hBFFF, 8'hE1);
    rd(16'h6010, 8'h77, "R2 mirror address loads control");
    wr(16'hA000, 8'h00);
    rd(16'h6010, 8'h77, "R2 even address ignored");

    // R7: offset aliasing above PAGE_AW bits (default 9)
    rd(16'h6210, 8'h77, "R7 offset alias");

    // R6: forced layout pulse
    wr(16'h5FF3, 8'h02);
    check("R6 pulse high", {7'b0, forceLayoutPulse}, 8'h01);
    @(negedge clk);
    check("R6 pulse one cycle", {7'b0, forceLayoutPulse}, 8'h00);
    wr(16'h5FF3, 8'h03);
    check("R6 other value no pulse", {7'b0, forceLayoutPulse}, 8'h00);
    wr(16'h5FF2, 8'h02);
    check("R6 other address no pulse", {7'b0, forceLayoutPulse}, 8'h00);
    rd(16'h5FF3, 8'h03, "R6 trigger address stored in xram");

    // R9: out-of-range read gives no valid
    @(negedge clk);
    cpuAddr = 16'h8000; cpuRdEn = 1'b1;
    @(negedge clk);
    cpuRdEn = 1'b0;
    check("R9 no valid outside range", {7'b0, rdValid}, 8'h00);

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", 8'(expQ.size()), 8'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule